// File: doc/BRIEF.md
# Slow Bus Access Synchronizer

This block sits between a fast processor core (around twenty times the host bus rate) and a slow host bus that runs at about 1 MHz. For every processor access it decides, in the same fast cycle, whether the access may complete at full speed, must go through the write cache, or must wait for the start of the next host bus cycle. It also enforces a recovery gap after each access to the video controller. The decision uses the address, the direction, the 64/128 operating mode and a 1 MHz phase reference that is synchronous to the fast clock.

The core holds `cpu_req`, `cpu_addr` and `cpu_we` stable until `cpu_ready` is high. A host-paced access completes in the first fast cycle in which the phase reference is sampled high after having been low, and `host_start` pulses in that cycle. Writes that the cache absorbs complete with `wr_accept`. They wait only while the cache reports busy and has not yet signalled done.

Top module: `slow_bus_sync`

## Requirements
- R1: After reset, with no request, `cpu_ready`, `host_start` and `wr_accept` are 0. A phase reference that is already high when reset is released does not count as a rising edge.
- R2: In 128 mode, a read or a write of $0001 or $FF00 stalls. It completes, with `host_start` high, in the first fast cycle in which `phi_ref` is 1 and was 0 in the previous cycle.
- R3: In 128 mode, reads of $D600, $D601 and $FF01 to $FF04 are paced like R2. Writes to those addresses complete through the cache (`wr_accept`=1, `host_start`=0).
- R4: In 64 mode, reads and writes of $0001 complete in the cycle they are presented, with no `host_start`.
- R5: Accesses to $D070-$D07F, $D0B0-$D0BF, $D200-$D3FF and all other addresses not named in R2, R3 or R6 complete in the cycle they are presented, in either mode.
- R6: Colour memory $D800-$DBFF: reads complete at once. Writes complete at once through the cache (`wr_accept`=1) when the cache is not busy.
- R7: A cache-bound write stalls while `wc_busy`=1 and `wc_done`=0. It completes in the cycle where `wc_done`=1 or `wc_busy`=0.
- R8: `host_start` is high only in a cycle where `cpu_ready` is high for a host-paced access. It is never high in two consecutive cycles, and never together with `wr_accept`.
- R9: In 128 mode, after an access to $D600/$D601 completes, the next access to either of them cannot complete before the cycle of the second phase-reference rising edge that follows.
- R10: In 64 mode, $D600/$D601 are ordinary full-speed addresses and set up no recovery gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access presented, held until ready |
| cpu_addr | input | 16 | Access address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| mode_128 | input | 1 | 1 = 128 mode, 0 = 64 mode |
| phi_ref | input | 1 | 1 MHz phase reference, synchronous to clk |
| wc_busy | input | 1 | Write cache busy with an earlier operation |
| wc_done | input | 1 | Write cache finishing its operation this cycle |
| cpu_ready | output | 1 | Access completes this cycle |
| host_start | output | 1 | One-cycle strobe: host bus cycle begins |
| wr_accept | output | 1 | Write handed to the cache this cycle |

## Verification
On every cycle the assertions check several properties. The strobe is tied to a detected phase edge and is one cycle long. It never coincides with a cache hand-off. The fixed register and scratch windows never stall. A busy cache blocks colour writes. Two video-controller accesses never complete back to back. The full recovery gap, with its two-edge spacing, can only be shown by the bench's scenarios. The same holds for the release exactly at the first edge after a stall, the behaviour around reset, and the per-mode treatment of $0001. The bench compares every cycle against a model built from the requirements.

// File: rtl/slow_bus_pkg.sv
package slow_bus_pkg;

   typedef enum logic [1:0] {
      ACC_FAST  = 2'd0,
      ACC_HOST  = 2'd1,
      ACC_CACHE = 2'd2
   } acc_kind_e;

endpackage

// File: rtl/sbs_phase_edge.sv
module sbs_phase_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic phi_ref,
   output logic phi_rise
);
   logic phi_s;
   logic phi_prev;

   generate
      if (SYNC_STAGES < 0) begin : g_bad
         $error("SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign phi_s = phi_ref;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk) begin
            if (!rst_n) sh <= '1;
            else        sh <= {sh[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], phi_ref};
         end
         assign phi_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) phi_prev <= 1'b1;
      else        phi_prev <= phi_s;
   end

   assign phi_rise = phi_s & ~phi_prev;
endmodule

// File: rtl/sbs_addr_class.sv
module sbs_addr_class
   import slow_bus_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              mode_128,
   output acc_kind_e         kind,
   output logic              is_vdc
);
   localparam logic [ADDR_W-1:0] A_PORT  = ADDR_W'(16'h0001);
   localparam logic [ADDR_W-1:0] A_MMU   = ADDR_W'(16'hFF00);
   localparam logic [ADDR_W-1:0] A_LCR_L = ADDR_W'(16'hFF01);
   localparam logic [ADDR_W-1:0] A_LCR_H = ADDR_W'(16'hFF04);
   localparam logic [ADDR_W-1:0] A_VDC0  = ADDR_W'(16'hD600);
   localparam logic [ADDR_W-1:0] A_VDC1  = ADDR_W'(16'hD601);
   localparam logic [ADDR_W-1:0] A_COL_L = ADDR_W'(16'hD800);
   localparam logic [ADDR_W-1:0] A_COL_H = ADDR_W'(16'hDBFF);

   generate
      if (ADDR_W < 16) begin : g_bad
         $error("ADDR_W must be at least 16");
      end
   endgenerate

   logic hit_both_dir;
   logic hit_read_slow;
   logic hit_colour;

   always_comb begin
      is_vdc        = mode_128 & ((addr == A_VDC0) | (addr == A_VDC1));
      hit_both_dir  = mode_128 & ((addr == A_PORT) | (addr == A_MMU));
      hit_read_slow = is_vdc | (mode_128 & (addr >= A_LCR_L) & (addr <= A_LCR_H));
      hit_colour    = (addr >= A_COL_L) & (addr <= A_COL_H);

      if (hit_both_dir)                    kind = ACC_HOST;
      else if (hit_read_slow && !we)       kind = ACC_HOST;
      else if (hit_read_slow && we)        kind = ACC_CACHE;
      else if (hit_colour && we)           kind = ACC_CACHE;
      else                                 kind = ACC_FAST;
   end
endmodule

// File: rtl/sbs_vdc_guard.sv
module sbs_vdc_guard #(
   parameter int HOLD_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic phi_rise,
   input  logic vdc_done,
   output logic vdc_ok
);
   localparam int LOAD  = HOLD_CYCLES + 1;
   localparam int CNT_W = $clog2(LOAD + 1);

   generate
      if (HOLD_CYCLES < 1) begin : g_bad
         $error("HOLD_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] gap_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                          gap_cnt <= '0;
      else if (vdc_done)                   gap_cnt <= CNT_W'(LOAD);
      else if (phi_rise && gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
   end

   assign vdc_ok = (gap_cnt == '0) | ((gap_cnt == CNT_W'(1)) & phi_rise);
endmodule

// File: rtl/slow_bus_sync.sv
module slow_bus_sync
   import slow_bus_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int SYNC_STAGES = 0,
   parameter int HOLD_CYCLES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_we,
   input  logic              mode_128,
   input  logic              phi_ref,
   input  logic              wc_busy,
   input  logic              wc_done,
   output logic              cpu_ready,
   output logic              host_start,
   output logic              wr_accept
);
   logic      ph_edge;
   acc_kind_e kind;
   logic      is_vdc;
   logic      vdc_ok;
   logic      go;
   logic      gate;

   sbs_phase_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .phi_ref  (phi_ref),
      .phi_rise (ph_edge)
   );

   sbs_addr_class #(.ADDR_W(ADDR_W)) u_class (
      .addr     (cpu_addr),
      .we       (cpu_we),
      .mode_128 (mode_128),
      .kind     (kind),
      .is_vdc   (is_vdc)
   );

   sbs_vdc_guard #(.HOLD_CYCLES(HOLD_CYCLES)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .phi_rise (ph_edge),
      .vdc_done (cpu_ready & is_vdc),
      .vdc_ok   (vdc_ok)
   );

   always_comb begin
      gate = ~is_vdc | vdc_ok;
      case (kind)
         ACC_HOST:  go = ph_edge & gate;
         ACC_CACHE: go = (~wc_busy | wc_done) & gate;
         default:   go = 1'b1;
      endcase
      cpu_ready  = cpu_req & go;
      host_start = cpu_ready & (kind == ACC_HOST);
      wr_accept  = cpu_ready & (kind == ACC_CACHE);
   end
endmodule

// File: rtl/slow_bus_sync_chk.sv
module slow_bus_sync_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_we,
   input logic              mode_128,
   input logic              wc_busy,
   input logic              wc_done,
   input logic              cpu_ready,
   input logic              host_start,
   input logic              wr_accept,
   input logic              ph_edge
);
   logic [15:0] a16;
   logic        win_fast;
   logic        col_wr;
   logic        vdc_acc;

   assign a16      = cpu_addr[15:0];
   assign win_fast = (a16[15:4] == 12'hD07) | (a16[15:4] == 12'hD0B) |
                     (a16[15:9] == 7'b1101_001);
   assign col_wr   = cpu_we & (a16[15:10] == 6'b1101_10);
   assign vdc_acc  = cpu_req & mode_128 & (a16[15:1] == 15'h6B00);

   AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      host_start |-> ph_edge && cpu_ready);                     // R8
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      host_start |=> !host_start);                              // R8
   AST_START_XOR_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_start && wr_accept));                              // R8
   AST_WINDOW_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && win_fast) |-> cpu_ready && !host_start);      // R5
   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && col_wr && wc_busy && !wc_done) |-> !cpu_ready); // R7
   AST_VDC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (vdc_acc && cpu_ready) |=> !(vdc_acc && cpu_ready));      // R9
endmodule

bind slow_bus_sync slow_bus_sync_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_req    (cpu_req),
   .cpu_addr   (cpu_addr),
   .cpu_we     (cpu_we),
   .mode_128   (mode_128),
   .wc_busy    (wc_busy),
   .wc_done    (wc_done),
   .cpu_ready  (cpu_ready),
   .host_start (host_start),
   .wr_accept  (wr_accept),
   .ph_edge    (ph_edge)
);

// File: tb/slow_bus_sync_tb_top.sv
`timescale 1ns/1ps
module slow_bus_sync_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_we = 1'b0;
   logic        mode_128 = 1'b0;
   logic        phi_ref = 1'b0;
   logic        wc_busy = 1'b0;
   logic        wc_done = 1'b0;
   logic        cpu_ready, host_start, wr_accept;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // model state
   bit   m_prev = 1'b1;
   int   m_gap  = 0;
   int   ph_cnt = 0;

   always #10 clk = ~clk;

   slow_bus_sync dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
      .cpu_we(cpu_we), .mode_128(mode_128), .phi_ref(phi_ref),
      .wc_busy(wc_busy), .wc_done(wc_done), .cpu_ready(cpu_ready),
      .host_start(host_start), .wr_accept(wr_accept)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d (addr=%h we=%0d m128=%0d)",
                  tag, what, act, exp, cpu_addr, cpu_we, mode_128);
      end
   endtask

   // 0 fast, 1 host paced, 2 cache
   function automatic int exp_kind(input logic [15:0] a, input bit w, input bit m);
      bit lcr = (a >= 16'hFF01) && (a <= 16'hFF04);
      bit vdc = (a == 16'hD600) || (a == 16'hD601);
      if (m && (a == 16'h0001 || a == 16'hFF00)) return 1;
      if (m && (lcr || vdc)) return w ? 2 : 1;
      if (w && a >= 16'hD800 && a <= 16'hDBFF) return 2;
      return 0;
   endfunction

   function automatic string tag_of(input logic [15:0] a, input bit w, input bit m,
                                    input bit blocked);
      int k = exp_kind(a, w, m);
      if (blocked) return "R9";
      if (k == 1) return (a == 16'h0001 || a == 16'hFF00) ? "R2" : "R3";
      if (k == 2) begin
         if (wc_busy) return "R7";
         return (a >= 16'hD800) ? "R6" : "R3";
      end
      if (!m && a == 16'h0001) return "R4";
      if (!m && (a == 16'hD600 || a == 16'hD601)) return "R10";
      if (a >= 16'hD800 && a <= 16'hDBFF) return "R6";
      return "R5";
   endfunction

   // one fast cycle: drive phase, check outputs, pass the edge, update model
   task automatic cycle(output bit done_acc);
      bit rise, vdc, vclear, blocked, e_rdy, e_st, e_acc;
      int k;
      ph_cnt++;
      phi_ref = ((ph_cnt % 20) >= 10);
      #2;
      rise    = phi_ref && !m_prev;
      k       = exp_kind(cpu_addr, cpu_we, mode_128);
      vdc     = mode_128 && (cpu_addr == 16'hD600 || cpu_addr == 16'hD601);
      vclear  = (m_gap == 0) || (m_gap == 1 && rise);
      blocked = cpu_req && vdc && !vclear;
      if (k == 0)      e_rdy = cpu_req;
      else if (k == 1) e_rdy = cpu_req && rise && (!vdc || vclear);
      else             e_rdy = cpu_req && (!wc_busy || wc_done) && (!vdc || vclear);
      e_st  = e_rdy && (k == 1);
      e_acc = e_rdy && (k == 2);
      if (cpu_req) begin
         chk(cpu_ready == e_rdy, tag_of(cpu_addr, cpu_we, mode_128, blocked),
             "cpu_ready", int'(cpu_ready), int'(e_rdy));
         chk(wr_accept == e_acc, (k == 2) ? "R7" : "R6", "wr_accept",
             int'(wr_accept), int'(e_acc));
      end
      chk(host_start == e_st, "R8", "host_start", int'(host_start), int'(e_st));
      done_acc = e_rdy;
      @(posedge clk);
      m_prev = phi_ref;
      if (e_rdy && vdc)            m_gap = 2;
      else if (rise && m_gap != 0) m_gap--;
      @(negedge clk);
   endtask

   task automatic access(input logic [15:0] a, input bit w, input bit m,
                         input int busy_n, input bit rnd_busy);
      bit d;
      int k = 0;
      cpu_req = 1'b1; cpu_addr = a; cpu_we = w; mode_128 = m;
      do begin
         if (rnd_busy) begin
            wc_busy = ($urandom % 3) == 0;
            wc_done = wc_busy && (($urandom % 4) == 0);
         end else begin
            wc_busy = (k < busy_n);
            wc_done = (k == busy_n - 1);
         end
         cycle(d);
         k++;
         if (k > 300) begin
            chk(1'b0, "R2", "access never completed", 0, 1);
            d = 1'b1;
         end
      end while (!d);
      cpu_req = 1'b0; wc_busy = 1'b0; wc_done = 1'b0;
   endtask

   function automatic logic [15:0] pick_addr();
      case ($urandom % 16)
         0:  return 16'h0001;
         1:  return 16'hFF00;
         2:  return 16'hD600;
         3:  return 16'hD601;
         4:  return 16'hFF01 + 16'($urandom % 4);
         5:  return 16'hD070 + 16'($urandom % 16);
         6:  return 16'hD0B0 + 16'($urandom % 16);
         7:  return 16'hD200 + 16'($urandom % 512);
         8:  return 16'hD800 + 16'($urandom % 1024);
         9:  return 16'hD600;
         10: return 16'hFF05;
         11: return 16'hD7FF;
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin
      bit d;
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: idle outputs in reset
      chk(!cpu_ready && !host_start && !wr_accept, "R1", "outputs in reset",
          int'({cpu_ready, host_start, wr_accept}), 0);
      // release reset with phase high and a paced access pending: no edge
      ph_cnt = 9;
      rst_n = 1'b1;
      cpu_req = 1'b1; cpu_addr = 16'h0001; cpu_we = 1'b0; mode_128 = 1'b1;
      phi_ref = 1'b1;
      #2;
      chk(!host_start && !cpu_ready, "R1", "no edge from high phase at reset",
          int'(host_start), 0);
      @(posedge clk); @(negedge clk);
      cpu_req = 1'b0;
      repeat (3) cycle(d);
      // directed corner cases
      access(16'h0001, 1'b0, 1'b1, 0, 1'b0);   // R2
      access(16'hFF00, 1'b1, 1'b1, 0, 1'b0);   // R2
      access(16'h0001, 1'b1, 1'b0, 0, 1'b0);   // R4
      access(16'hFF03, 1'b0, 1'b1, 0, 1'b0);   // R3
      access(16'hFF04, 1'b1, 1'b1, 0, 1'b0);   // R3
      access(16'hD07A, 1'b1, 1'b1, 0, 1'b0);   // R5
      access(16'hD0B3, 1'b0, 1'b1, 0, 1'b0);   // R5
      access(16'hD3FF, 1'b1, 1'b0, 0, 1'b0);   // R5
      access(16'hDA00, 1'b0, 1'b0, 0, 1'b0);   // R6
      access(16'hDA00, 1'b1, 1'b0, 0, 1'b0);   // R6
      access(16'hD800, 1'b1, 1'b1, 7, 1'b0);   // R7
      access(16'hD600, 1'b0, 1'b1, 0, 1'b0);   // R9
      access(16'hD601, 1'b0, 1'b1, 0, 1'b0);   // R9
      access(16'hD600, 1'b1, 1'b1, 0, 1'b0);   // R9
      access(16'hD601, 1'b1, 1'b1, 0, 1'b0);   // R9
      access(16'hD600, 1'b0, 1'b0, 0, 1'b0);   // R10
      access(16'hD601, 1'b1, 1'b0, 0, 1'b0);   // R10
      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [15:0] a = pick_addr();
         access(a, 1'($urandom % 2), 1'($urandom % 4 != 0), 0, 1'b1);
         if ($urandom % 5 == 0) cycle(d);
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 190000);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL R8 watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule